// File: doc/BRIEF.md
# Host Bus Register Port with DMA Streaming

This block is the slave side of an asynchronous-style parallel host bus, observed in the system clock domain. A host addresses it with a 4-bit address plus active-low chip-select, read and write strobes. Writes load six byte-wide setting registers that downstream logic consumes. Reads return a status byte, a block-number byte, or the next word of a 22-byte corrected packet supplied by a producer.

The ready output has two handshake styles. In the default style ready falls while the port prepares the data and rises when the data is driven. In the alternate style ready stays high while the data is prepared, falls while the data is driven and rises when the host lets go of the strobe. A DMA mode raises a request while packet bytes remain unread. It forces a byte-wide bus and can take its read strobe from the acknowledge input. The request and acknowledge polarities are each selectable. The data bus is modelled as values plus output enables for the low and high byte lanes.

Top module: `hbus_port`

## Requirements
- R1: After reset every setting register output is zero, rdy is 1, oe_lo and oe_hi are 0 and dreq is 1.
- R2: A write (cs_n and wr_n low) to address 1, 2, 3, 4, 5 or 6 loads wdata into bic_lim, bsync_lim, fsync_lim, ctrl1, ctrl2 or crc_byte respectively. A write to address 6 also raises crc_stb for exactly one cycle.
- R3: Writes to address 0 or to addresses 7 to 15 change no setting register and give no crc_stb pulse.
- R4: A read of address 1 returns stat_in, a read of address 2 returns blk_in, and reads of addresses 3 to 15 return zero, in the low byte with the high byte zero.
- R5: With ctrl2 bit 3 clear, rdy is low for WAIT_CYC cycles before oe_lo rises. It is then high for as long as the data is driven, and the data stays constant while driven.
- R6: With ctrl2 bit 3 set, rdy stays high before the data is driven, is low for every cycle oe_lo is high, and is high again once the strobe is released.
- R7: Reads of address 0 return packet bytes in order from byte 0, where byte k is pkt_bus[8k+7:8k]. In byte mode one byte is returned per read. In 16-bit mode the low lane carries byte k and the high lane byte k+1, and the pointer advances by two. Reads beyond the last byte return zero. A pkt_load pulse restarts the stream at byte 0.
- R8: oe_hi is high only while oe_lo is high, bus_wide is 1 and DMA is off.
- R9: With ctrl2 bit 0 set, the request is active while unread packet bytes remain and no read is in progress. It goes inactive from the start of a read until the strobe is released. The bus is byte-wide in this mode.
- R10: With ctrl2 bits 0 and 1 set, the acknowledge input is the read strobe, rd_n is ignored, and the read returns packet data whatever the address.
- R11: ctrl2 bit 4 makes dreq active-high (default active-low). ctrl2 bit 5 makes dack active-high (default active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Register address |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data (low byte lane) |
| bus_wide | input | 1 | 1 selects a 16-bit data bus |
| dack | input | 1 | DMA acknowledge, polarity set by ctrl2 bit 5 |
| pkt_load | input | 1 | Pulse: a new packet is present on pkt_bus |
| pkt_bus | input | PKT_BYTES*8 | Corrected packet, byte k at bits 8k+7:8k |
| stat_in | input | 8 | Status byte returned at address 1 |
| blk_in | input | 8 | Block number returned at address 2 |
| rdata | output | 16 | Read data, zero when not driven |
| oe_lo | output | 1 | Low byte lane driven |
| oe_hi | output | 1 | High byte lane driven |
| rdy | output | 1 | Ready handshake |
| dreq | output | 1 | DMA request, polarity set by ctrl2 bit 4 |
| bic_lim | output | 8 | Setting register at address 1 |
| bsync_lim | output | 8 | Setting register at address 2 |
| fsync_lim | output | 8 | Setting register at address 3 |
| ctrl1 | output | 8 | Setting register at address 4 |
| ctrl2 | output | 8 | Setting register at address 5 (mode bits) |
| crc_byte | output | 8 | Byte most recently written to address 6 |
| crc_stb | output | 1 | One-cycle pulse per write to address 6 |

## Verification
The assertions take for granted that the host holds the address and its strobe steady until the port has driven the data. They also take for granted that ctrl2 is not rewritten while a read is in progress, and that successive writes are separated by a release of the write strobe. The stimulus drives every input at the falling clock edge. Each access is a task that asserts a strobe, waits until the data has been seen for several cycles, releases the strobe and idles before the next access. Mode changes are made only between accesses, and the acknowledge line is moved to its idle level before its polarity bit is changed.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
   typedef enum logic [1:0] {PH_IDLE, PH_WAIT, PH_DRIVE} phase_t;

   localparam int ADDR_W   = 4;
   localparam int REG_W    = 8;
   localparam int NUM_WREG = 6;

   localparam logic [ADDR_W-1:0] RA_PKT  = 4'd0;
   localparam logic [ADDR_W-1:0] RA_STAT = 4'd1;
   localparam logic [ADDR_W-1:0] RA_BLK  = 4'd2;
   localparam logic [ADDR_W-1:0] WA_CRC  = 4'd6;

   localparam int C2_DMA    = 0;
   localparam int C2_ACKRD  = 1;
   localparam int C2_RDYALT = 3;
   localparam int C2_REQPOL = 4;
   localparam int C2_ACKPOL = 5;
endpackage

// File: rtl/hbp_wreg_bank.sv
module hbp_wreg_bank
   import hbp_pkg::*;
#(
   parameter int NREG = NUM_WREG,
   parameter int DW   = REG_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_pulse,
   input  logic [ADDR_W-1:0]         waddr,
   input  logic [DW-1:0]             wdata,
   output logic [NREG:1][DW-1:0]     regs,
   output logic                      crc_stb
);
   genvar gi;
   generate
      for (gi = 1; gi <= NREG; gi++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[gi] <= '0;
            else if (wr_pulse && (waddr == ADDR_W'(gi)))
               regs[gi] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_stb <= 1'b0;
      else        crc_stb <= wr_pulse && (waddr == WA_CRC);
   end
endmodule

// File: rtl/hbp_phase_ctl.sv
module hbp_phase_ctl
   import hbp_pkg::*;
#(
   parameter int WAIT_CYC = 3
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   strobe_q,
   output phase_t phase,
   output logic   start,
   output logic   done
);
   localparam int CW = $clog2(WAIT_CYC + 1);
   logic [CW-1:0] cnt;

   assign start = (phase == PH_IDLE)  &&  strobe_q;
   assign done  = (phase == PH_DRIVE) && !strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (start) begin
               phase <= PH_WAIT;
               cnt   <= CW'(WAIT_CYC - 1);
            end
            PH_WAIT: if (cnt == '0) phase <= PH_DRIVE;
                     else           cnt   <= cnt - 1'b1;
            PH_DRIVE: if (done) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hbp_rd_src.sv
module hbp_rd_src
   import hbp_pkg::*;
#(
   parameter int NBYTES  = 22,
   parameter int HOST_DW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pkt_load,
   input  logic [NBYTES*8-1:0]   pkt_bus,
   input  logic [REG_W-1:0]      stat_in,
   input  logic [REG_W-1:0]      blk_in,
   input  logic                  sel_pkt,
   input  logic [ADDR_W-1:0]     sel_addr,
   input  logic                  wide,
   input  logic                  start,
   input  logic                  done,
   output logic [HOST_DW-1:0]    word,
   output logic                  more
);
   localparam int PW = $clog2(NBYTES + 3);
   logic [PW-1:0] ptr;
   logic          src_pkt_q, wide_q;
   logic [7:0]    lo_b, hi_b;

   function automatic logic [7:0] pick(input logic [NBYTES*8-1:0] v, input int idx);
      if (idx < NBYTES) return v[idx*8 +: 8];
      return 8'h00;
   endfunction

   assign more = (int'(ptr) < NBYTES);

   always_comb begin
      lo_b = 8'h00;
      hi_b = 8'h00;
      if (sel_pkt) begin
         lo_b = pick(pkt_bus, int'(ptr));
         if (wide) hi_b = pick(pkt_bus, int'(ptr) + 1);
      end else if (sel_addr == RA_STAT) lo_b = stat_in;
      else if (sel_addr == RA_BLK)      lo_b = blk_in;
   end

   generate
      if (HOST_DW == 16) begin : g_wide
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word <= '0;
            else if (start) word <= {hi_b, lo_b};
         end
      end else begin : g_narrow
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     word <= '0;
            else if (start) word <= lo_b;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         src_pkt_q <= 1'b0;
         wide_q    <= 1'b0;
      end else begin
         if (start) begin
            src_pkt_q <= sel_pkt;
            wide_q    <= wide;
         end
         if (pkt_load)
            ptr <= '0;
         else if (done && src_pkt_q && more)
            ptr <= ((int'(ptr) + (wide_q ? 2 : 1)) > NBYTES) ? PW'(NBYTES)
                   : ptr + (wide_q ? PW'(2) : PW'(1));
      end
   end
endmodule

// File: rtl/hbus_port.sv
module hbus_port
   import hbp_pkg::*;
#(
   parameter int PKT_BYTES = 22,
   parameter int WAIT_CYC  = 3,
   parameter int HOST_DW   = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [3:0]              addr,
   input  logic                    cs_n,
   input  logic                    rd_n,
   input  logic                    wr_n,
   input  logic [7:0]              wdata,
   input  logic                    bus_wide,
   input  logic                    dack,
   input  logic                    pkt_load,
   input  logic [PKT_BYTES*8-1:0]  pkt_bus,
   input  logic [7:0]              stat_in,
   input  logic [7:0]              blk_in,
   output logic [15:0]             rdata,
   output logic                    oe_lo,
   output logic                    oe_hi,
   output logic                    rdy,
   output logic                    dreq,
   output logic [7:0]              bic_lim,
   output logic [7:0]              bsync_lim,
   output logic [7:0]              fsync_lim,
   output logic [7:0]              ctrl1,
   output logic [7:0]              ctrl2,
   output logic [7:0]              crc_byte,
   output logic                    crc_stb
);
   generate
      if (PKT_BYTES < 2)  begin : g_bad_len  $error("PKT_BYTES must be at least 2"); end
      if (WAIT_CYC < 1)   begin : g_bad_wait $error("WAIT_CYC must be at least 1");  end
      if (HOST_DW != 16 && HOST_DW != 8) begin : g_bad_dw $error("HOST_DW must be 8 or 16"); end
   endgenerate

   logic [ADDR_W-1:0]          addr_q;
   logic [7:0]                 wdata_q;
   logic                       strobe_q, wr_q, wr_qd, wr_pulse;
   logic                       ack_rd, ack_act, strobe_now, wide_eff, more, start, done, req;
   logic [NUM_WREG:1][7:0]     regs;
   logic [HOST_DW-1:0]         word;
   phase_t                     phase;

   assign ack_rd     = ctrl2[C2_DMA] & ctrl2[C2_ACKRD];
   assign ack_act    = ctrl2[C2_ACKPOL] ? dack : ~dack;
   assign strobe_now = ack_rd ? ack_act : (~cs_n & ~rd_n);
   assign wide_eff   = bus_wide & ~ctrl2[C2_DMA] & (HOST_DW == 16);
   assign wr_pulse   = wr_q & ~wr_qd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q   <= '0;
         wdata_q  <= '0;
         strobe_q <= 1'b0;
         wr_q     <= 1'b0;
         wr_qd    <= 1'b0;
      end else begin
         addr_q   <= addr;
         wdata_q  <= wdata;
         strobe_q <= strobe_now;
         wr_q     <= ~cs_n & ~wr_n;
         wr_qd    <= wr_q;
      end
   end

   hbp_wreg_bank #(.NREG(NUM_WREG), .DW(8)) u_wregs (
      .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .waddr(addr_q),
      .wdata(wdata_q), .regs(regs), .crc_stb(crc_stb));

   assign bic_lim   = regs[1];
   assign bsync_lim = regs[2];
   assign fsync_lim = regs[3];
   assign ctrl1     = regs[4];
   assign ctrl2     = regs[5];
   assign crc_byte  = regs[6];

   hbp_phase_ctl #(.WAIT_CYC(WAIT_CYC)) u_phase (
      .clk(clk), .rst_n(rst_n), .strobe_q(strobe_q),
      .phase(phase), .start(start), .done(done));

   hbp_rd_src #(.NBYTES(PKT_BYTES), .HOST_DW(HOST_DW)) u_src (
      .clk(clk), .rst_n(rst_n), .pkt_load(pkt_load), .pkt_bus(pkt_bus),
      .stat_in(stat_in), .blk_in(blk_in),
      .sel_pkt(ack_rd || (addr_q == RA_PKT)), .sel_addr(addr_q),
      .wide(wide_eff), .start(start), .done(done), .word(word), .more(more));

   assign oe_lo = (phase == PH_DRIVE);
   assign oe_hi = oe_lo & wide_eff;
   assign rdata = oe_lo ? 16'(word) : 16'h0000;
   assign rdy   = ctrl2[C2_RDYALT] ? (phase != PH_DRIVE) : (phase != PH_WAIT);
   assign req   = ctrl2[C2_DMA] & more & (phase == PH_IDLE) & ~strobe_q;
   assign dreq  = ctrl2[C2_REQPOL] ? req : ~req;
endmodule

// File: rtl/hbus_port_chk.sv
module hbus_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wide,
   input logic [15:0] rdata,
   input logic        oe_lo,
   input logic        oe_hi,
   input logic        rdy,
   input logic        dreq,
   input logic [7:0]  ctrl2,
   input logic        crc_stb
);
   p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      crc_stb |=> !crc_stb);

   p_drive_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_lo && $past(oe_lo)) |-> $stable(rdata));

   p_rdy_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl2[3] && oe_lo) |-> rdy);

   p_rdy_alt_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl2[3] && !oe_lo) |-> rdy);

   p_hi_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
      oe_hi |-> (oe_lo && bus_wide));

   p_dma_narrow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl2[0] |-> !oe_hi);

   p_req_off_in_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      oe_lo |-> (dreq == !ctrl2[4]));

   p_undriven_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_lo |-> (rdata == 16'h0000));
endmodule

bind hbus_port hbus_port_chk i_chk (
   .clk(clk), .rst_n(rst_n), .bus_wide(bus_wide), .rdata(rdata),
   .oe_lo(oe_lo), .oe_hi(oe_hi), .rdy(rdy), .dreq(dreq),
   .ctrl2(ctrl2), .crc_stb(crc_stb));

// File: tb/test_hbus_port.sv
`timescale 1ns/1ps
module test_hbus_port;
   localparam int NB = 22;
   localparam int WC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] addr = '0;
   logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [7:0] wdata = '0;
   logic bus_wide = 1'b0, dack = 1'b1, pkt_load = 1'b0;
   logic [NB*8-1:0] pkt_bus;
   logic [7:0] stat_in = 8'hA5, blk_in = 8'h3C;
   logic [15:0] rdata;
   logic oe_lo, oe_hi, rdy, dreq, crc_stb;
   logic [7:0] bic_lim, bsync_lim, fsync_lim, ctrl1, ctrl2, crc_byte;

   int checks = 0, errors = 0, crc_pulses = 0, cyc = 0;
   bit ack_hi = 1'b0;

   always #2 clk = ~clk;

   hbus_port #(.PKT_BYTES(NB), .WAIT_CYC(WC)) i_hbus_port (.*);

   function automatic logic [7:0] pb(input int k);
      return (k < NB) ? 8'(8'h30 + k * 5) : 8'h00;
   endfunction

   initial for (int k = 0; k < NB; k++) pkt_bus[k*8 +: 8] = pb(k);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural reference model, advanced on every rising edge
   int   m_phase, m_cnt, m_ptr, m_aq, m_dq;
   bit   m_sq, m_wq, m_wqd, m_stb, m_srcpkt, m_wide;
   logic [7:0]  m_reg [1:6];
   logic [15:0] m_word;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_ptr = 0; m_aq = 0; m_dq = 0;
         m_sq = 0; m_wq = 0; m_wqd = 0; m_stb = 0; m_srcpkt = 0; m_wide = 0;
         m_word = 0;
         for (int i = 1; i <= 6; i++) m_reg[i] = 0;
      end else begin
         bit c2dma, ackrd, strb, st, dn, wp, wide, selp;
         c2dma = m_reg[5][0];
         ackrd = c2dma && m_reg[5][1];
         strb  = ackrd ? (m_reg[5][5] ? dack : !dack) : (!cs_n && !rd_n);
         wide  = bus_wide && !c2dma;
         st    = (m_phase == 0) && m_sq;
         dn    = (m_phase == 2) && !m_sq;
         wp    = m_wq && !m_wqd;
         selp  = ackrd || (m_aq == 0);
         if (st) begin
            m_srcpkt = selp; m_wide = wide;
            if (selp) m_word = wide ? {pb(m_ptr + 1), pb(m_ptr)} : {8'h00, pb(m_ptr)};
            else if (m_aq == 1) m_word = {8'h00, stat_in};
            else if (m_aq == 2) m_word = {8'h00, blk_in};
            else m_word = 0;
         end
         if (pkt_load) m_ptr = 0;
         else if (dn && m_srcpkt && m_ptr < NB) m_ptr = (m_ptr + (m_wide ? 2 : 1) > NB) ? NB : m_ptr + (m_wide ? 2 : 1);
         if (m_phase == 0) begin if (st) begin m_phase = 1; m_cnt = WC; end end
         else if (m_phase == 1) begin m_cnt--; if (m_cnt == 0) m_phase = 2; end
         else if (dn) m_phase = 0;
         m_stb = wp && (m_aq == 6);
         if (wp && m_aq >= 1 && m_aq <= 6) m_reg[m_aq] = m_dq[7:0];
         m_sq = strb; m_wqd = m_wq; m_wq = !cs_n && !wr_n; m_aq = addr; m_dq = wdata;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit reqm, mrdy, moe;
         logic [21:0] exp_pins, act_pins;
         moe  = (m_phase == 2);
         mrdy = m_reg[5][3] ? !moe : (m_phase != 1);
         reqm = m_reg[5][0] && (m_ptr < NB) && (m_phase == 0) && !m_sq;
         exp_pins = {mrdy, moe, moe && bus_wide && !m_reg[5][0],
                     m_reg[5][4] ? reqm : !reqm, m_stb, 1'b0, moe ? m_word : 16'h0};
         act_pins = {rdy, oe_lo, oe_hi, dreq, crc_stb, 1'b0, rdata};
         chk(exp_pins === act_pins, "R5 R6 R9 model pins", act_pins, exp_pins);
         chk({bic_lim, bsync_lim, fsync_lim, ctrl1} === {m_reg[1], m_reg[2], m_reg[3], m_reg[4]}
             && {ctrl2, crc_byte} === {m_reg[5], m_reg[6]}, "R2 model regs",
             {ctrl1, ctrl2, crc_byte}, {m_reg[4], m_reg[5], m_reg[6]});
         if (crc_stb) crc_pulses++;
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; cs_n = 0; wr_n = 0;
      @(negedge clk); cs_n = 1; wr_n = 1;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input logic [3:0] a, input bit via_ack, output logic [15:0] d,
                     output int wl, output int dl, output bit hi, output bit rq);
      int n_oe = 0;
      d = 0; wl = 0; dl = 0; hi = 0; rq = 0;
      @(negedge clk); addr = a;
      if (via_ack) dack = ack_hi; else begin cs_n = 0; rd_n = 0; end
      for (int j = 0; j < 40; j++) begin
         @(negedge clk);
         if (oe_lo) begin
            if (n_oe == 0) begin d = rdata; hi = oe_hi; rq = dreq; end
            n_oe++;
            if (!rdy) dl++;
         end else if (!rdy) wl++;
         if (n_oe >= 3) break;
      end
      cs_n = 1; rd_n = 1; dack = !ack_hi;
      repeat (4) @(negedge clk);
   endtask

   task automatic load_pkt();
      @(negedge clk); pkt_load = 1;
      @(negedge clk); pkt_load = 0;
   endtask

   initial begin : wd
      while (cyc < 100000) begin @(negedge clk); cyc++; end
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d; int wl, dl; bit hi, rq;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk({bic_lim, bsync_lim, fsync_lim, ctrl1, ctrl2, crc_byte} == 0, "R1 regs", ctrl2, 0);
      chk(rdy && !oe_lo && !oe_hi && dreq, "R1 pins", {rdy, oe_lo, oe_hi, dreq}, 4'b1001);
      rst_n = 1;
      repeat (2) @(negedge clk);
      // R2 writes
      for (int i = 1; i <= 6; i++) wr(4'(i), (i == 5) ? 8'h40 : 8'(8'h11 * i));
      chk(bic_lim == 8'h11 && bsync_lim == 8'h22 && fsync_lim == 8'h33, "R2 limits", {bic_lim, bsync_lim, fsync_lim}, 24'h112233);
      chk(ctrl1 == 8'h44 && ctrl2 == 8'h40 && crc_byte == 8'h66, "R2 ctrl", {ctrl1, ctrl2, crc_byte}, 24'h444066);
      chk(crc_pulses == 1, "R2 crc_stb", crc_pulses, 1);
      // R3 prohibited writes
      wr(4'd0, 8'hEE); wr(4'd7, 8'hEE); wr(4'd15, 8'hEE);
      chk({bic_lim, bsync_lim, fsync_lim, ctrl1, ctrl2, crc_byte} == 48'h112233444066, "R3 ignored",
          {ctrl1, ctrl2, crc_byte}, 24'h444066);
      chk(crc_pulses == 1, "R3 no crc_stb", crc_pulses, 1);
      // R4 / R5 register reads in default ready style
      rd(4'd1, 0, d, wl, dl, hi, rq);
      chk(d == 16'h00A5, "R4 stat", d, 16'h00A5);
      chk(wl == WC && dl == 0, "R5 rdy default", {wl, dl}, {WC, 0});
      rd(4'd2, 0, d, wl, dl, hi, rq);
      chk(d == 16'h003C, "R4 blk", d, 16'h003C);
      rd(4'd9, 0, d, wl, dl, hi, rq);
      chk(d == 16'h0000, "R4 reserved", d, 0);
      // R7 byte stream
      load_pkt();
      for (int k = 0; k < NB; k++) begin
         rd(4'd0, 0, d, wl, dl, hi, rq);
         chk(d == {8'h00, pb(k)}, "R7 byte order", d, {8'h00, pb(k)});
      end
      rd(4'd0, 0, d, wl, dl, hi, rq);
      chk(d == 0, "R7 past end", d, 0);
      // R7 / R8 16-bit
      bus_wide = 1; load_pkt();
      rd(4'd0, 0, d, wl, dl, hi, rq);
      chk(d == {pb(1), pb(0)} && hi, "R8 wide word", {hi, d}, {1'b1, pb(1), pb(0)});
      rd(4'd0, 0, d, wl, dl, hi, rq);
      chk(d == {pb(3), pb(2)}, "R7 wide advance", d, {pb(3), pb(2)});
      // R6 alternate ready
      wr(4'd5, 8'h08);
      rd(4'd1, 0, d, wl, dl, hi, rq);
      chk(wl == 0 && dl == 3 && rdy, "R6 rdy alt", {wl, dl}, {0, 3});
      // R9 DMA
      wr(4'd5, 8'h01); load_pkt();
      @(negedge clk);
      chk(dreq == 1'b0, "R9 request pending", dreq, 0);
      rd(4'd0, 0, d, wl, dl, hi, rq);
      chk(d == {8'h00, pb(0)} && !hi && rq, "R9 narrow read, request off", {hi, rq, d}, {2'b01, 8'h00, pb(0)});
      // R10 acknowledge as strobe
      wr(4'd5, 8'h03);
      @(negedge clk); cs_n = 0; rd_n = 0; addr = 4'd1;
      repeat (8) begin @(negedge clk); chk(!oe_lo, "R10 rd_n ignored", oe_lo, 0); end
      cs_n = 1; rd_n = 1; repeat (2) @(negedge clk);
      rd(4'd5, 1, d, wl, dl, hi, rq);
      chk(d == {8'h00, pb(1)}, "R10 ack read", d, {8'h00, pb(1)});
      // R11 polarities
      wr(4'd5, 8'h21); ack_hi = 1; dack = 0;
      wr(4'd5, 8'h33);
      @(negedge clk);
      chk(dreq == 1'b1, "R11 request active high", dreq, 1);
      rd(4'd0, 1, d, wl, dl, hi, rq);
      chk(d == {8'h00, pb(2)} && !rq, "R11 ack active high", {rq, d}, {1'b0, 8'h00, pb(2)});
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule